// File: doc/BRIEF.md
# Nibble-Stream Ethernet Receive Framer

This block sits behind a media-independent receive interface that delivers one 4-bit nibble per clock, at 2.5 MHz for 10 Mb/s links and at 25 MHz for 100 Mb/s links. It looks for the start of a frame, which is a run of 0x5 nibbles closed by a 0xD delimiter nibble. Every nibble after the delimiter goes on to a downstream FIFO with a valid strobe. A single-cycle last marker accompanies the final nibble.

While the frame passes through, the block compares the destination address with a 48-bit station address and detects group (multicast or broadcast) destinations. It also runs a nibble-serial CRC-32 over all nibbles after the delimiter, counts those nibbles, and records media errors and over-length frames. When receive-valid drops, it packs these results into a 16-bit status word and marks it with a one-cycle, active-low strobe.

Top module: `mii_rx_framer`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid and out_last are 0, stat_valid_n is 1 and stat_word is 0.
- R2: Nibbles before the 0xD delimiter are never forwarded, and neither is the delimiter itself. If a nibble other than 0x5 or 0xD appears before the delimiter, the rest of that burst of mii_dv is discarded, with no output and no status.
- R3: Every nibble after the delimiter appears on out_nib with out_valid high, in arrival order and one per clock. out_last is high together with the final nibble of the frame and on no other cycle.
- R4: At frame end, stat_valid_n goes low for exactly one clock. If the frame carried any nibble, this is the same cycle as out_last. stat_word keeps its value until the next frame end.
- R5: stat_word[15:4] holds the number of nibbles after the delimiter, FCS included, and saturates at 4095.
- R6: stat_word[0] is 1 when mii_err was high on any data nibble of the frame, or when the nibble count exceeds 3036.
- R7: stat_word[1] is 1 when the first 12 data nibbles equal station_addr. Nibble 2k is bits [3:0] of byte k and nibble 2k+1 is bits [7:4], where byte k is station_addr[47-8k -: 8]. Frames with fewer than 12 nibbles give 0.
- R8: stat_word[2] is 1 for a frame of at least 12 nibbles whose first nibble has bit 0 set, or whose first 12 nibbles are all 0xF.
- R9: stat_word[3] is 1 exactly when the CRC-32 (polynomial 0x04C11DB7, seed all ones, bits of each nibble taken LSB first) over all data nibbles ends at the residue 0xC704DD7B.
- R10: A delimiter followed directly by the fall of mii_dv produces a status pulse with length 0 and no out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | receive clock, one nibble per cycle |
| rst | input | 1 | synchronous active-high reset |
| station_addr | input | 48 | station address, first transmitted byte in bits 47:40 |
| mii_dv | input | 1 | receive data valid |
| mii_nib | input | 4 | receive nibble, meaningful while mii_dv is high |
| mii_err | input | 1 | media error flag for the current nibble |
| out_nib | output | 4 | nibble passed to the FIFO |
| out_valid | output | 1 | out_nib carries a frame nibble |
| out_last | output | 1 | marks the final nibble of a frame |
| stat_word | output | 16 | packed receive status |
| stat_valid_n | output | 1 | low for one clock when stat_word is fresh |

## Verification
Length saturation and the over-length error are the two cases that are hard to reach. Both need frames of thousands of nibbles that still carry a correct FCS, so that the effect of length can be told apart from a CRC failure. The bench builds these frames itself: it appends an FCS computed with a reflected CRC in the bench, then drives 3040-nibble and 4120-nibble frames. These sit among random frames with varied preamble lengths, destination modes, injected media errors and corrupted FCS values.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    localparam int NIB_W    = 4;
    localparam int LEN_W    = 12;
    localparam int ADDR_W   = 48;
    localparam int ADDR_NIB = ADDR_W / NIB_W;
    localparam int IDX_W    = $clog2(ADDR_NIB + 1);
    localparam int CRC_W    = 32;

    localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
    localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;

    localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_SEED    = 32'hFFFFFFFF;
    localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704DD7B;

    typedef enum logic [1:0] {
        ST_SEEK,
        ST_DATA,
        ST_DROP
    } rx_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             crc_ok;
        logic             group;
        logic             match;
        logic             fault;
    } rx_stat_t;

    // Advance the CRC register by one nibble, lowest bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [NIB_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int b = 0; b < NIB_W; b++) begin
            fb = r[CRC_W-1] ^ d[b];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    // Expected nibble of the station address at receive position idx.
    function automatic logic [NIB_W-1:0] addr_nib(input logic [ADDR_W-1:0] addr,
                                                  input logic [IDX_W-1:0]  idx);
        logic [ADDR_W-1:0] sh;
        int                byte_no;
        byte_no = int'(idx) >> 1;
        sh      = addr >> (ADDR_W - 8 - 8 * byte_no);
        return idx[0] ? sh[7:4] : sh[3:0];
    endfunction

endpackage

// File: rtl/mii_rx_crc.sv
module mii_rx_crc
    import mii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [NIB_W-1:0] nib,
    output logic             crc_ok
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= CRC_SEED;
        else if (en)    crc_q <= crc_step(crc_q, nib);
    end

    assign crc_ok = (crc_q == CRC_RESIDUE);

    // R9: the register stays put while no data nibble is accepted
    p_crc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(crc_q));
endmodule

// File: rtl/mii_rx_addr.sv
module mii_rx_addr
    import mii_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [NIB_W-1:0]  nib,
    input  logic [ADDR_W-1:0] station,
    output logic              da_match,
    output logic              da_group
);
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(ADDR_NIB);

    logic [IDX_W-1:0] idx_q;
    logic             match_q;
    logic             bcast_q;
    logic             mcast_q;
    logic             in_addr;

    assign in_addr = (idx_q != IDX_FULL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx_q   <= '0;
            match_q <= 1'b1;
            bcast_q <= 1'b1;
            mcast_q <= 1'b0;
        end else if (en && in_addr) begin
            idx_q <= idx_q + 1'b1;
            if (nib != addr_nib(station, idx_q)) match_q <= 1'b0;
            if (nib != '1)                       bcast_q <= 1'b0;
            if (idx_q == '0)                     mcast_q <= nib[0];
        end
    end

    assign da_match = !in_addr && match_q;
    assign da_group = !in_addr && (mcast_q || bcast_q);

    // R7: once the full address is in, the verdict is frozen until the next frame
    p_addr_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (!in_addr && !clr) |=> ($stable(match_q) && $stable(bcast_q) && $stable(mcast_q)));
endmodule

// File: rtl/mii_rx_len.sv
module mii_rx_len
    import mii_rx_pkg::*;
#(
    parameter int MAX_NIB = 3036
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    output logic [LEN_W-1:0] count,
    output logic             too_long
);
    localparam logic [LEN_W-1:0] CNT_TOP = '1;
    localparam logic [LEN_W-1:0] CNT_MAX = LEN_W'(MAX_NIB);

    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)                cnt_q <= '0;
        else if (en && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign count    = cnt_q;
    assign too_long = (cnt_q > CNT_MAX);

    // R5: the counter saturates instead of wrapping
    p_len_sat_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_TOP && !clr) |=> (cnt_q == CNT_TOP));
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
    import mii_rx_pkg::*;
#(
    parameter int MAX_NIB = 3036
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [47:0] station_addr,
    input  logic        mii_dv,
    input  logic [3:0]  mii_nib,
    input  logic        mii_err,
    output logic [3:0]  out_nib,
    output logic        out_valid,
    output logic        out_last,
    output logic [15:0] stat_word,
    output logic        stat_valid_n
);
    rx_state_e        state_q;
    logic [NIB_W-1:0] hold_nib_q;
    logic             hold_full_q;
    logic             err_q;
    rx_stat_t         stat_q;

    logic             frame_clr;
    logic             data_en;
    logic             crc_ok;
    logic             da_match;
    logic             da_group;
    logic [LEN_W-1:0] nib_count;
    logic             too_long;
    rx_stat_t         stat_next;

    assign frame_clr = (state_q == ST_SEEK) && mii_dv && (mii_nib == SFD_NIB);
    assign data_en   = (state_q == ST_DATA) && mii_dv;

    mii_rx_crc u_crc (
        .clk    (clk),
        .rst    (rst),
        .clr    (frame_clr),
        .en     (data_en),
        .nib    (mii_nib),
        .crc_ok (crc_ok)
    );

    mii_rx_addr u_addr (
        .clk      (clk),
        .rst      (rst),
        .clr      (frame_clr),
        .en       (data_en),
        .nib      (mii_nib),
        .station  (station_addr),
        .da_match (da_match),
        .da_group (da_group)
    );

    mii_rx_len #(.MAX_NIB(MAX_NIB)) u_len (
        .clk      (clk),
        .rst      (rst),
        .clr      (frame_clr),
        .en       (data_en),
        .count    (nib_count),
        .too_long (too_long)
    );

    always_comb begin
        stat_next.len    = nib_count;
        stat_next.crc_ok = crc_ok;
        stat_next.group  = da_group;
        stat_next.match  = da_match;
        stat_next.fault  = err_q || too_long;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_SEEK;
            hold_nib_q   <= '0;
            hold_full_q  <= 1'b0;
            err_q        <= 1'b0;
            stat_q       <= '0;
            out_nib      <= '0;
            out_valid    <= 1'b0;
            out_last     <= 1'b0;
            stat_valid_n <= 1'b1;
        end else begin
            out_valid    <= 1'b0;
            out_last     <= 1'b0;
            stat_valid_n <= 1'b1;
            unique case (state_q)
                ST_SEEK: begin
                    if (mii_dv) begin
                        if (mii_nib == SFD_NIB) begin
                            state_q     <= ST_DATA;
                            hold_full_q <= 1'b0;
                            err_q       <= 1'b0;
                        end else if (mii_nib != PRE_NIB) begin
                            state_q <= ST_DROP;
                        end
                    end
                end
                ST_DROP: begin
                    if (!mii_dv) state_q <= ST_SEEK;
                end
                ST_DATA: begin
                    if (mii_dv) begin
                        hold_nib_q  <= mii_nib;
                        hold_full_q <= 1'b1;
                        if (mii_err) err_q <= 1'b1;
                        if (hold_full_q) begin
                            out_nib   <= hold_nib_q;
                            out_valid <= 1'b1;
                        end
                    end else begin
                        state_q      <= ST_SEEK;
                        hold_full_q  <= 1'b0;
                        stat_q       <= stat_next;
                        stat_valid_n <= 1'b0;
                        if (hold_full_q) begin
                            out_nib   <= hold_nib_q;
                            out_valid <= 1'b1;
                            out_last  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_SEEK;
            endcase
        end
    end

    assign stat_word = stat_q;

    // R3: the last marker only ever travels with a valid nibble
    p_last_valid_r3: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
    // R4: status strobe is a single-cycle pulse
    p_stat_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        !stat_valid_n |=> stat_valid_n);
    // R4: the last nibble and the status strobe coincide
    p_last_stat_r4: assert property (@(posedge clk) disable iff (rst)
        out_last |-> !stat_valid_n);
    // R4: status word only changes together with its strobe
    p_stat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        stat_valid_n |-> $stable(stat_word));
    // R2: a discarded burst forwards nothing
    p_drop_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DROP) |=> (!out_valid && stat_valid_n));
endmodule

// File: tb/mii_rx_framer_tb_top.sv
module mii_rx_framer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [47:0] station;
    logic        dv;
    logic [3:0]  nib;
    logic        err;
    logic [3:0]  out_nib;
    logic        out_valid;
    logic        out_last;
    logic [15:0] stat_word;
    logic        stat_valid_n;

    always #10 clk = ~clk;

    mii_rx_framer dut_i (
        .clk          (clk),
        .rst          (rst),
        .station_addr (station),
        .mii_dv       (dv),
        .mii_nib      (nib),
        .mii_err      (err),
        .out_nib      (out_nib),
        .out_valid    (out_valid),
        .out_last     (out_last),
        .stat_word    (stat_word),
        .stat_valid_n (stat_valid_n)
    );

    int checks = 0;
    int errors = 0;

    logic [3:0]  fr  [0:4199];
    int          fr_n;
    logic [3:0]  got [0:4199];
    int          got_n, last_cnt, last_idx, stat_cnt;
    logic        stat_last;
    logic [15:0] stat_val;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (got_n < 4200) got[got_n] = out_nib;
                if (out_last) begin
                    last_cnt++;
                    last_idx = got_n;
                end
                got_n++;
            end else if (out_last) begin
                last_cnt++;
            end
            if (!stat_valid_n) begin
                stat_cnt++;
                stat_val  = stat_word;
                stat_last = out_last;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_refl(input int n);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 4; b++) begin
                fb = c[0] ^ fr[i][b];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        return c;
    endfunction

    function automatic logic [3:0] st_nib(input int i);
        logic [7:0] by;
        by = station[47 - 8 * (i / 2) -: 8];
        return (i % 2 == 1) ? by[7:4] : by[3:0];
    endfunction

    function automatic logic [15:0] exp_stat(input bit errflag);
        bit m, allf, g, c, e;
        int len;
        m    = (fr_n >= 12);
        allf = (fr_n >= 12);
        for (int i = 0; i < 12 && i < fr_n; i++) begin
            if (fr[i] != st_nib(i)) m = 1'b0;
            if (fr[i] != 4'hF)      allf = 1'b0;
        end
        g   = (fr_n >= 12) && (fr[0][0] || allf);
        c   = (crc_refl(fr_n) == 32'hDEBB20E3);
        e   = errflag || (fr_n > 3036);
        len = (fr_n > 4095) ? 4095 : fr_n;
        return {len[11:0], c, g, m, e};
    endfunction

    // mode 0: station, 1: broadcast, 2: random individual, 3: random group
    task automatic build(input int mode, input int pay, input bit bad_fcs);
        logic [31:0] fcs;
        fr_n = 0;
        for (int i = 0; i < 12; i++) begin
            case (mode)
                0:       fr[i] = st_nib(i);
                1:       fr[i] = 4'hF;
                default: fr[i] = 4'($urandom);
            endcase
        end
        if (mode == 2) fr[0][0] = 1'b0;
        if (mode == 3) fr[0][0] = 1'b1;
        fr_n = 12;
        for (int i = 0; i < pay; i++) begin
            fr[fr_n] = 4'($urandom);
            fr_n++;
        end
        fcs = ~crc_refl(fr_n);
        for (int k = 0; k < 8; k++) begin
            fr[fr_n] = fcs[4*k +: 4];
            fr_n++;
        end
        if (bad_fcs) fr[fr_n-1][2] = ~fr[fr_n-1][2];
    endtask

    task automatic send(input int pre, input bit bad_pre, input int err_pos);
        got_n = 0; last_cnt = 0; last_idx = -1; stat_cnt = 0; stat_last = 1'b0;
        for (int i = 0; i < pre; i++) begin
            @(negedge clk); dv = 1'b1; nib = 4'h5; err = 1'b0;
        end
        if (bad_pre) begin
            @(negedge clk); dv = 1'b1; nib = 4'h3;
        end
        @(negedge clk); dv = 1'b1; nib = 4'hD;
        for (int i = 0; i < fr_n; i++) begin
            @(negedge clk); nib = fr[i]; err = (i == err_pos);
        end
        @(negedge clk); dv = 1'b0; nib = 4'h0; err = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic verify(input bit errflag, input bit dropped);
        int          mism;
        logic [15:0] es;
        if (dropped) begin
            chk(got_n == 0,    "R2 discarded burst forwarded nibbles", got_n, 0);
            chk(stat_cnt == 0, "R2 discarded burst gave status", stat_cnt, 0);
            return;
        end
        mism = 0;
        for (int i = 0; i < fr_n && i < got_n; i++)
            if (got[i] != fr[i]) mism++;
        chk(got_n == fr_n, "R3 forwarded nibble count", got_n, fr_n);
        chk(mism == 0,     "R3 forwarded nibble values", mism, 0);
        if (fr_n > 0)
            chk(last_cnt == 1 && last_idx == fr_n - 1, "R3 last marker position",
                last_idx, fr_n - 1);
        else
            chk(last_cnt == 0 && got_n == 0, "R10 empty frame forwarded data", got_n, 0);
        chk(stat_cnt == 1, "R4 status strobe count", stat_cnt, 1);
        chk(stat_last == (fr_n > 0), "R4 strobe aligned with last", stat_last, fr_n > 0);
        chk(stat_word == stat_val, "R4 status held after strobe", stat_word, stat_val);
        es = exp_stat(errflag);
        chk(stat_val[15:4] == es[15:4], "R5 length field", stat_val[15:4], es[15:4]);
        chk(stat_val[0] == es[0], "R6 fault bit", stat_val[0], es[0]);
        chk(stat_val[1] == es[1], "R7 address match bit", stat_val[1], es[1]);
        chk(stat_val[2] == es[2], "R8 group bit", stat_val[2], es[2]);
        chk(stat_val[3] == es[3], "R9 crc bit", stat_val[3], es[3]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        station = 48'h02_1A_3C_4D_5E_6F;
        rst = 1'b1; dv = 1'b0; nib = 4'h0; err = 1'b0;
        got_n = 0; last_cnt = 0; last_idx = -1; stat_cnt = 0; stat_last = 1'b0;
        stat_val = '0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_last && stat_valid_n && stat_word == 16'h0,
            "R1 outputs during reset", {out_valid, out_last, stat_valid_n}, 3'b001);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && stat_valid_n && stat_word == 16'h0,
            "R1 outputs after reset", stat_word, 0);

        // directed: unicast to station, good FCS
        build(0, 100, 1'b0); send(7, 1'b0, -1); verify(1'b0, 1'b0);
        // broadcast, delimiter without preamble
        build(1, 40, 1'b0);  send(0, 1'b0, -1); verify(1'b0, 1'b0);
        // group destination, corrupted FCS
        build(3, 30, 1'b1);  send(4, 1'b0, -1); verify(1'b0, 1'b0);
        // media error on a payload nibble
        build(0, 20, 1'b0);  send(5, 1'b0, 17); verify(1'b1, 1'b0);
        // bad preamble nibble discards the burst
        build(0, 20, 1'b0);  send(3, 1'b1, -1); verify(1'b0, 1'b1);
        // short frame below address length
        fr_n = 5;
        for (int i = 0; i < 5; i++) fr[i] = st_nib(i);
        send(6, 1'b0, -1); verify(1'b0, 1'b0);
        // R10: empty frame
        fr_n = 0; send(6, 1'b0, -1); verify(1'b0, 1'b0);
        // over length but good FCS (3040 nibbles)
        build(0, 3020, 1'b0); send(8, 1'b0, -1); verify(1'b0, 1'b0);
        // length saturation (4120 nibbles)
        build(2, 4100, 1'b0); send(8, 1'b0, -1); verify(1'b0, 1'b0);

        // random frames
        for (int t = 0; t < 25; t++) begin
            int  mode, pay, pre, epos;
            bit  bad;
            mode = int'($urandom % 4);
            pay  = int'($urandom % 200);
            pre  = int'($urandom % 16);
            bad  = ($urandom % 4) == 0;
            build(mode, pay, bad);
            epos = (($urandom % 6) == 0) ? int'($urandom % fr_n) : -1;
            send(pre, 1'b0, epos);
            verify(epos >= 0, 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule